// File: doc/BRIEF.md
# Clock Control Register Bank

This block is the software-visible register file of a clock controller. A host reaches it through a plain word-addressed bus that carries an address, write data, a write strobe, a read strobe and read data. Behind the bus sit these registers:

- one core mode register;
- two post-divider registers;
- two PLL control registers;
- three clock-gating registers;
- one power-management status word.

Each writable register filters incoming data through its own write mask. The mode register also has one bit that every write forces to 1. One address answers with a fixed constant word.

A separate frequency engine consumes the mode, divider and PLL registers through dedicated output ports. The bank tells that engine when to recompute with a single-cycle pulse. The pulse fires after any write that can change a frequency, and once when the bank leaves reset.

The bus has no back-pressure. Either strobe is accepted on every clock edge. Read data comes back registered, one cycle after the read strobe, and keeps that value until the next read.

Top module: `clkctl_regbank`

## Requirements
- R1: On reset the registers read back as follows: word 0 (mode) 0x074B0B7B, word 1 (divider A) 0xFF870B48, word 2 (divider B) 0x49FCFE7F, word 4 (main PLL) 0x04001800, word 6 (aux PLL) 0x04043001, words 8, 9 and 10 (gating) 0xFFFFFFFF, and word 23 (power) 0x80209828. While reset is held, read data is 0.
- R2: A write to word 0 stores (wdata & 0x3B6FDFFF) with bit 26 set to 1.
- R3: A write to word 1 stores (wdata & 0xFF9F3FFF). A write to word 2 stores all 32 bits.
- R4: A write to word 4 or word 6 stores (wdata & 0xBFFF3FFF).
- R5: Writes to words 8 to 10 store all 32 bits and raise no recompute pulse.
- R6: A read of word 18 always returns 0x00004040, and a write to word 18 changes nothing and raises no pulse.
- R7: A read of any unmapped word returns 0. A write to an unmapped word changes nothing and raises no pulse.
- R8: Word 23 cannot be written from the bus. Writes to it leave it unchanged and raise no pulse.
- R9: A write to word 0, 1, 2, 4 or 6 drives `recompute` high for exactly the one clock that follows the write edge. In that same clock the new register value is already visible on the bank outputs. Back-to-back writes give back-to-back pulses.
- R10: `recompute` stays low while reset is held, and pulses once in the first clock after reset is released.
- R11: Read data is valid in the cycle after the read strobe and holds its value while no read is issued. If a read and a write hit the same word in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| recompute | output | 1 | One-cycle request to the frequency engine |
| mode_o | output | 32 | Current mode register |
| div_a_o | output | 32 | Current divider A register |
| div_b_o | output | 32 | Current divider B register |
| pll_main_o | output | 32 | Current main PLL register |
| pll_aux_o | output | 32 | Current aux PLL register |

## Verification
The hardest cases to reach from the ports are the ones that depend on how two events line up in time. The first is a read and a write landing on the same word in one cycle. The second is the reset-exit pulse relative to later writes. The bench drives both strobes together on one edge and checks that the old word comes back, then reads again to see the new one. It also reasserts reset in the middle of a run to show that the boot pulse fires a second time and the reset constants return. Back-to-back writes check that consecutive pulses never merge into one or disappear.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DW   = 32;
  localparam int NREG = 9;

  // storage index: 0 mode, 1 div_a, 2 div_b, 3 pll_main, 4 pll_aux,
  // 5..7 gating, 8 power
  localparam int CONST_OFS = 18;
  localparam logic [DW-1:0] CONST_VAL = 32'h0000_4040;

  function automatic int reg_ofs(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 4;
      4: return 6;
      5: return 8;
      6: return 9;
      7: return 10;
      default: return 23;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_rst(input int i);
    case (i)
      0: return 32'h074B_0B7B;
      1: return 32'hFF87_0B48;
      2: return 32'h49FC_FE7F;
      3: return 32'h0400_1800;
      4: return 32'h0404_3001;
      5, 6, 7: return 32'hFFFF_FFFF;
      default: return 32'h8020_9828;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_wmask(input int i);
    case (i)
      0: return 32'h3B6F_DFFF;
      1: return 32'hFF9F_3FFF;
      3, 4: return 32'hBFFF_3FFF;
      8: return 32'h0000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_force(input int i);
    return (i == 0) ? 32'h0400_0000 : 32'h0;
  endfunction

  function automatic bit reg_writable(input int i);
    return i != 8;
  endfunction

  function automatic logic [NREG-1:0] kick_mask();
    logic [NREG-1:0] m;
    m = '0;
    for (int i = 0; i < NREG; i++) m[i] = (i <= 4);
    return m;
  endfunction
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit,
  output logic            const_hit
);
  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = (addr == AW'(reg_ofs(g)));
  end
  assign const_hit = (addr == AW'(CONST_OFS));
endmodule

// File: rtl/ccr_storage.sv
module ccr_storage
  import ccr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREG-1:0]          wr_sel,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] RST_V = reg_rst(g);
    localparam logic [DW-1:0] MASK  = reg_wmask(g);
    localparam logic [DW-1:0] FORCE = reg_force(g);
    if (reg_writable(g)) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst)            regs[g] <= RST_V;
        else if (wr_sel[g]) regs[g] <= (wdata & MASK) | FORCE;
      end
    end else begin : g_ro
      assign regs[g] = RST_V;
    end
  end
endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
  import ccr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [NREG-1:0]         rd_sel,
  input  logic                    const_sel,
  input  logic [NREG-1:0][DW-1:0] regs,
  output logic [DW-1:0]           rdata
);
  logic [DW-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_sel[i]) word = word | regs[i];
    if (const_sel) word = CONST_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word;
  end
endmodule

// File: rtl/ccr_kick.sv
module ccr_kick
  import ccr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] wr_sel,
  output logic            pulse
);
  localparam logic [NREG-1:0] KICK = kick_mask();
  logic boot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q <= 1'b1;
      pulse  <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      pulse  <= boot_q | (|(wr_sel & KICK));
    end
  end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import ccr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  output logic          recompute,
  output logic [31:0]   mode_o,
  output logic [31:0]   div_a_o,
  output logic [31:0]   div_b_o,
  output logic [31:0]   pll_main_o,
  output logic [31:0]   pll_aux_o
);
  logic [NREG-1:0]         hit;
  logic                    const_hit;
  logic [NREG-1:0]         wr_sel;
  logic [NREG-1:0][DW-1:0] regs;

  ccr_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .hit(hit), .const_hit(const_hit)
  );

  assign wr_sel = hit & {NREG{bus_wr}};

  ccr_storage u_store (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(bus_wdata), .regs(regs)
  );

  ccr_rdmux u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .rd_sel(hit),
    .const_sel(const_hit), .regs(regs), .rdata(bus_rdata)
  );

  ccr_kick u_kick (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .pulse(recompute)
  );

  assign mode_o     = regs[0];
  assign div_a_o    = regs[1];
  assign div_b_o    = regs[2];
  assign pll_main_o = regs[3];
  assign pll_aux_o  = regs[4];
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [31:0]   bus_rdata,
  input logic          recompute,
  input logic [31:0]   mode_o,
  input logic [31:0]   pll_main_o
);
  logic seen_q;
  logic kick_addr;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  assign kick_addr = (bus_addr == AW'(0)) || (bus_addr == AW'(1)) ||
                     (bus_addr == AW'(2)) || (bus_addr == AW'(4)) ||
                     (bus_addr == AW'(6));

  // R9
  kick_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && kick_addr) |=> recompute);

  // R5
  no_spurious_kick_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !(bus_wr && kick_addr)) |=> !recompute);

  // R6
  const_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(18)) |=> (bus_rdata == 32'h0000_4040));

  // R8
  power_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(23)) |=> (bus_rdata == 32'h8020_9828));

  // R2
  mode_forced_bit_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> mode_o[26]);

  // R4
  pll_masked_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(4)) |=> (pll_main_o[30] == 1'b0 && pll_main_o[15:14] == 2'b00));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !bus_rd) |=> $stable(bus_rdata));
endmodule

bind clkctl_regbank clkctl_regbank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .recompute(recompute),
  .mode_o(mode_o), .pll_main_o(pll_main_o)
);

// File: tb/clkctl_regbank_bench.sv
`timescale 1ns/1ps
module clkctl_regbank_bench;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic recompute;
  logic [31:0] mode_o, div_a_o, div_b_o, pll_main_o, pll_aux_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkctl_regbank #(.AW(AW)) u_clkctl_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .recompute(recompute), .mode_o(mode_o), .div_a_o(div_a_o),
    .div_b_o(div_b_o), .pll_main_o(pll_main_o), .pll_aux_o(pll_aux_o)
  );

  // {addr[8], wdata[32], expected readback[32], expected pulse, req id[4]}
  localparam int NV = 14;
  localparam logic [76:0] VEC [NV] = '{
    {8'd0,  32'hFFFFFFFF, 32'h3F6FDFFF, 1'b1, 4'd2},
    {8'd0,  32'h00000000, 32'h04000000, 1'b1, 4'd2},
    {8'd1,  32'hFFFFFFFF, 32'hFF9F3FFF, 1'b1, 4'd3},
    {8'd1,  32'h12345678, 32'h12141678, 1'b1, 4'd3},
    {8'd2,  32'hA5A5A5A5, 32'hA5A5A5A5, 1'b1, 4'd3},
    {8'd4,  32'hFFFFFFFF, 32'hBFFF3FFF, 1'b1, 4'd4},
    {8'd6,  32'h40004000, 32'h00000000, 1'b1, 4'd4},
    {8'd8,  32'h00000000, 32'h00000000, 1'b0, 4'd5},
    {8'd9,  32'h12345678, 32'h12345678, 1'b0, 4'd5},
    {8'd10, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 4'd5},
    {8'd23, 32'h00000000, 32'h80209828, 1'b0, 4'd8},
    {8'd18, 32'h00000000, 32'h00004040, 1'b0, 4'd6},
    {8'd3,  32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd7},
    {8'd63, 32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd7}
  };

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", bus_rdata, 32'h0);
    chk("R10", {31'b0, recompute}, 32'h0);

    rst = 1'b0;
    @(negedge clk);
    chk("R10", {31'b0, recompute}, 32'h1);
    @(negedge clk);
    chk("R10", {31'b0, recompute}, 32'h0);

    do_read(6'd0);  chk("R1", bus_rdata, 32'h074B0B7B);
    do_read(6'd1);  chk("R1", bus_rdata, 32'hFF870B48);
    do_read(6'd2);  chk("R1", bus_rdata, 32'h49FCFE7F);
    do_read(6'd4);  chk("R1", bus_rdata, 32'h04001800);
    do_read(6'd6);  chk("R1", bus_rdata, 32'h04043001);
    do_read(6'd8);  chk("R1", bus_rdata, 32'hFFFFFFFF);
    do_read(6'd9);  chk("R1", bus_rdata, 32'hFFFFFFFF);
    do_read(6'd10); chk("R1", bus_rdata, 32'hFFFFFFFF);
    do_read(6'd23); chk("R1", bus_rdata, 32'h80209828);
    chk("R1", pll_aux_o, 32'h04043001);

    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      string rq;
      a  = VEC[i][69+AW-1:69];
      rq = req_name(VEC[i][3:0]);
      do_write(a, VEC[i][68:37]);
      chk(VEC[i][4] ? "R9" : rq, {31'b0, recompute}, {31'b0, VEC[i][4]});
      @(negedge clk);
      chk(VEC[i][4] ? "R9" : rq, {31'b0, recompute}, 32'h0);
      do_read(a);
      chk(rq, bus_rdata, VEC[i][36:5]);
    end

    // same-cycle read and write to divider B returns the old word
    @(negedge clk);
    bus_addr = 6'd2; bus_wdata = 32'h11111111; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R11", bus_rdata, 32'hA5A5A5A5);
    chk("R9", div_b_o, 32'h11111111);
    repeat (3) @(negedge clk);
    chk("R11", bus_rdata, 32'hA5A5A5A5);
    do_read(6'd2);
    chk("R11", bus_rdata, 32'h11111111);

    // back-to-back kicking writes
    @(negedge clk);
    bus_addr = 6'd0; bus_wdata = 32'h0; bus_wr = 1'b1;
    @(negedge clk);
    chk("R9", {31'b0, recompute}, 32'h1);
    bus_addr = 6'd4; bus_wdata = 32'h00001400;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R9", {31'b0, recompute}, 32'h1);
    chk("R4", pll_main_o, 32'h00001400);
    @(negedge clk);
    chk("R9", {31'b0, recompute}, 32'h0);

    // reset in mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", {31'b0, recompute}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", {31'b0, recompute}, 32'h1);
    chk("R1", mode_o, 32'h074B0B7B);
    @(negedge clk);
    chk("R10", {31'b0, recompute}, 32'h0);
    do_read(6'd2);
    chk("R1", bus_rdata, 32'h49FCFE7F);

    finish_run();
  end
endmodule